// File: doc/BRIEF.md
# Issue Hazard Scoreboard

This block sits in the decode stage of an in-order pipeline that feeds floating-point units with different latencies. Each cycle it looks at one decoded candidate: its unit class, up to two source registers and an optional destination. It decides in the same cycle whether the candidate may leave decode. A small associative table holds every destination that has issued but not yet written back. A down-counter models the one unit that cannot accept back-to-back work, the divide/square-root unit.

A candidate is held when any of these is true:
- a source it reads is still pending (read-after-write);
- its destination is still pending (write-after-write);
- the table has no free slot for its destination;
- it needs the divider while the divider is still occupied.

Write-after-read needs no check, because operands are read in decode. Every register identifier carries a file bit, so integer and floating-point registers with the same number are tracked as separate registers. Integer register 0 is hard-wired and is never tracked.

Top module: `issue_scoreboard`

## Requirements
- R1: While reset is held and immediately after it, no register is pending (`pend_valid` all zero), `div_busy` is low, and `stall` is low when `cand_valid` is low.
- R2: A valid candidate whose used source register matches a pending entry stalls. A match needs the same number and the same file bit (`*_fp`=1 for floating-point, 0 for integer). Integer n and floating-point n never match each other.
- R3: A valid candidate whose used destination matches a pending entry stalls.
- R4: Integer register 0 (file bit 0, number 0) never becomes pending and never causes a stall, as source or as destination.
- R5: Unit codes are 0 integer, 1 FP add, 2 FP multiply, 3 divide/sqrt. After a divide issues, `div_busy` is high from the next cycle, and a further divide stalls. The further divide can issue exactly `DIV_II` (default 25) cycles after the first one. Add, multiply and integer candidates are never held by the divider.
- R6: On issue, a tracked destination is recorded at the clock edge. A retire report clears the matching entry at the clock edge. A candidate in the same cycle as the retire still sees the entry.
- R7: A retire report for a register that is not pending, or for integer register 0, leaves the table unchanged.
- R8: When all `ENTRIES` slots are pending, a candidate with a tracked destination stalls. A candidate without a destination is not held by a full table.
- R9: `issue` and `stall` are never high together. Exactly one of them is high when `cand_valid` is high, and both are low otherwise. Both follow the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cand_valid | input | 1 | A decoded candidate is present |
| cand_unit | input | 2 | Unit class: 0 int, 1 add, 2 mul, 3 div/sqrt |
| src1_use | input | 1 | Source 1 is read |
| src1_fp | input | 1 | Source 1 file: 1 FP, 0 integer |
| src1_num | input | REG_W | Source 1 register number |
| src2_use | input | 1 | Source 2 is read |
| src2_fp | input | 1 | Source 2 file |
| src2_num | input | REG_W | Source 2 register number |
| dst_use | input | 1 | Candidate writes a destination |
| dst_fp | input | 1 | Destination file |
| dst_num | input | REG_W | Destination register number |
| ret_valid | input | 1 | Write-back retire report present |
| ret_fp | input | 1 | Retiring register file |
| ret_num | input | REG_W | Retiring register number |
| issue | output | 1 | Candidate leaves decode this cycle |
| stall | output | 1 | Candidate is held this cycle |
| div_busy | output | 1 | Divide/sqrt unit cannot accept work |
| pend_valid | output | ENTRIES | Occupied slots of the pending table |

## Verification
The main function is tried with a vector sequence that builds up state. It mixes these candidates:
- read-after-write hits against a pending entry;
- write-after-write hits against a pending entry;
- the same register number in the other file, which must pass;
- integer register 0 as source and as destination;
- a full table;
- candidates with no destination.

Each vector tells a real hazard apart from a near miss on file bit or number. Directed sequences then place a retire in the same cycle as a dependent candidate, to separate edge-timed clearing from combinational bypass. They also sweep divide candidates cycle by cycle after a divide, so that an off-by-one in the busy window shows up as an issue in the wrong cycle.

// File: rtl/issue_scoreboard.sv
module issue_scoreboard #(
  parameter int REG_W   = 5,
  parameter int ENTRIES = 4,
  parameter int DIV_II  = 25
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cand_valid,
  input  logic [1:0]         cand_unit,
  input  logic               src1_use,
  input  logic               src1_fp,
  input  logic [REG_W-1:0]   src1_num,
  input  logic               src2_use,
  input  logic               src2_fp,
  input  logic [REG_W-1:0]   src2_num,
  input  logic               dst_use,
  input  logic               dst_fp,
  input  logic [REG_W-1:0]   dst_num,
  input  logic               ret_valid,
  input  logic               ret_fp,
  input  logic [REG_W-1:0]   ret_num,
  output logic               issue,
  output logic               stall,
  output logic               div_busy,
  output logic [ENTRIES-1:0] pend_valid
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int CNT_W = $clog2(DIV_II + 1);
  localparam logic [1:0] UNIT_DIV = 2'd3;

  logic [ENTRIES-1:0] ent_v, ent_fp;
  logic [REG_W-1:0]   ent_num [ENTRIES];
  logic [ENTRIES-1:0] m_s1, m_s2, m_dst, m_ret;
  logic [CNT_W-1:0]   div_cnt;
  logic [IDX_W-1:0]   free_idx;

  wire s1_need  = src1_use && (src1_fp || src1_num != '0);
  wire s2_need  = src2_use && (src2_fp || src2_num != '0);
  wire dst_need = dst_use  && (dst_fp  || dst_num  != '0);
  wire ret_need = ret_valid && (ret_fp || ret_num  != '0);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign m_s1[g]  = ent_v[g] && ent_fp[g] == src1_fp && ent_num[g] == src1_num;
    assign m_s2[g]  = ent_v[g] && ent_fp[g] == src2_fp && ent_num[g] == src2_num;
    assign m_dst[g] = ent_v[g] && ent_fp[g] == dst_fp  && ent_num[g] == dst_num;
    assign m_ret[g] = ent_v[g] && ent_fp[g] == ret_fp  && ent_num[g] == ret_num;
  end

  wire raw_hit = (s1_need && |m_s1) || (s2_need && |m_s2);
  wire waw_hit = dst_need && |m_dst;
  wire tbl_full = dst_need && &ent_v;
  wire div_blk = cand_unit == UNIT_DIV && div_cnt != '0;

  assign stall      = cand_valid && (raw_hit || waw_hit || tbl_full || div_blk);
  assign issue      = cand_valid && !stall;
  assign div_busy   = div_cnt != '0;
  assign pend_valid = ent_v;

  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!ent_v[i]) free_idx = IDX_W'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_v  <= '0;
      ent_fp <= '0;
      for (int i = 0; i < ENTRIES; i++) ent_num[i] <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (ret_need && m_ret[i]) ent_v[i] <= 1'b0;
        if (issue && dst_need && free_idx == IDX_W'(i)) begin
          ent_v[i]   <= 1'b1;
          ent_fp[i]  <= dst_fp;
          ent_num[i] <= dst_num;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              div_cnt <= '0;
    else if (issue && cand_unit == UNIT_DIV) div_cnt <= CNT_W'(DIV_II - 1);
    else if (div_cnt != '0)                  div_cnt <= div_cnt - 1'b1;
  end
endmodule

// File: rtl/issue_scoreboard_chk.sv
module issue_scoreboard_chk #(
  parameter int REG_W   = 5,
  parameter int ENTRIES = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cand_valid,
  input logic [1:0]         cand_unit,
  input logic               dst_use,
  input logic               dst_fp,
  input logic [REG_W-1:0]   dst_num,
  input logic               ret_valid,
  input logic               issue,
  input logic               stall,
  input logic               div_busy,
  input logic [ENTRIES-1:0] pend_valid
);
  wire dst_track = dst_use && (dst_fp || dst_num != '0);

  p_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (issue || stall) == cand_valid && !(issue && stall));

  p_div_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    issue && cand_unit == 2'd3 |=> div_busy);

  p_div_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    div_busy && cand_unit == 2'd3 |-> !issue);

  p_alloc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    issue && dst_track && !ret_valid |=>
      $countones(pend_valid) == $past($countones(pend_valid)) + 1);

  p_zero_reg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    issue && dst_use && !dst_fp && dst_num == '0 && !ret_valid |=> $stable(pend_valid));

  p_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    &pend_valid && dst_track |-> !issue);
endmodule

bind issue_scoreboard issue_scoreboard_chk #(.REG_W(REG_W), .ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cand_valid(cand_valid), .cand_unit(cand_unit),
  .dst_use(dst_use), .dst_fp(dst_fp), .dst_num(dst_num), .ret_valid(ret_valid),
  .issue(issue), .stall(stall), .div_busy(div_busy), .pend_valid(pend_valid)
);

// File: tb/tb_issue_scoreboard.sv
`timescale 1ns/100ps
module tb_issue_scoreboard;
  localparam int ENTRIES = 4;
  localparam int DIV_II  = 25;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cand_valid = 0, src1_use = 0, src1_fp = 0, src2_use = 0, src2_fp = 0;
  logic dst_use = 0, dst_fp = 0, ret_valid = 0, ret_fp = 0;
  logic [1:0] cand_unit = 0;
  logic [4:0] src1_num = 0, src2_num = 0, dst_num = 0, ret_num = 0;
  logic issue, stall, div_busy;
  logic [ENTRIES-1:0] pend_valid;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  issue_scoreboard #(.REG_W(5), .ENTRIES(ENTRIES), .DIV_II(DIV_II)) dut (.*);

  typedef struct packed {
    logic cv; logic [1:0] u;
    logic s1u; logic [5:0] s1;
    logic s2u; logic [5:0] s2;
    logic du;  logic [5:0] d;
    logic rv;  logic [5:0] r;
    logic ei;  logic [3:0] np;
  } vec_t;

  localparam logic [1:0] INT = 0, ADD = 1, MUL = 2, DIV = 3;
  localparam logic [5:0] F = 6'h20;
  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{1, ADD, 1, F+4,  1, F+6,  1, F+2,  0, 0,    1, 0},
    '{1, MUL, 1, F+2,  1, F+0,  1, F+8,  0, 0,    0, 1},
    '{1, ADD, 1, F+10, 1, F+12, 1, F+2,  0, 0,    0, 1},
    '{1, INT, 1, 2,    1, 3,    1, 2,    0, 0,    1, 1},
    '{1, INT, 1, 0,    1, 0,    1, 0,    0, 0,    1, 2},
    '{1, INT, 1, 0,    1, 2,    1, 5,    0, 0,    0, 2},
    '{1, INT, 1, 2,    0, 0,    1, 5,    1, 2,    0, 2},
    '{1, INT, 1, 2,    0, 0,    1, 5,    0, 0,    1, 1},
    '{1, DIV, 1, F+4,  1, F+6,  1, F+20, 0, 0,    1, 2},
    '{1, ADD, 1, F+1,  1, F+3,  1, F+7,  0, 0,    1, 3},
    '{1, INT, 1, 1,    0, 0,    1, 9,    0, 0,    0, 4},
    '{1, INT, 1, 1,    0, 0,    0, 0,    0, 0,    1, 4},
    '{0, ADD, 0, 0,    0, 0,    0, 0,    1, F+7,  0, 4},
    '{1, DIV, 1, F+1,  0, 0,    1, F+22, 0, 0,    0, 3},
    '{0, INT, 0, 0,    0, 0,    0, 0,    1, 0,    0, 3},
    '{0, INT, 0, 0,    0, 0,    0, 0,    1, F+9,  0, 3},
    '{1, INT, 1, 1,    0, 0,    1, 9,    0, 0,    1, 3},
    '{0, INT, 0, 0,    0, 0,    0, 0,    0, 0,    0, 4}
  };
  localparam string TAG [NV] = '{"R9", "R2", "R3", "R2", "R4", "R2", "R6", "R6", "R5",
                                  "R5", "R8", "R8", "R9", "R5", "R7", "R7", "R8", "R8"};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    cand_valid = v.cv; cand_unit = v.u;
    src1_use = v.s1u; src1_fp = v.s1[5]; src1_num = v.s1[4:0];
    src2_use = v.s2u; src2_fp = v.s2[5]; src2_num = v.s2[4:0];
    dst_use = v.du; dst_fp = v.d[5]; dst_num = v.d[4:0];
    ret_valid = v.rv; ret_fp = v.r[5]; ret_num = v.r[4:0];
    #1;
  endtask

  function automatic vec_t cand(input logic [1:0] u, input logic [5:0] s, input logic [5:0] d);
    vec_t v = '0;
    v.cv = 1; v.u = u; v.s1u = 1; v.s1 = s; v.du = 1; v.d = d;
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    vec_t v;
    int k;
    repeat (2) @(negedge clk);
    #1;
    chk("R1 pend_valid in reset", int'(pend_valid), 0);
    chk("R1 div_busy in reset", int'(div_busy), 0);
    chk("R1 stall idle in reset", int'(stall), 0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      chk({TAG[i], " issue"}, int'(issue), int'(VEC[i].ei));
      chk({TAG[i], " stall"}, int'(stall), int'(VEC[i].cv && !VEC[i].ei));
      chk({TAG[i], " pending count"}, $countones(pend_valid), int'(VEC[i].np));
    end

    // R6/R8: retire frees a slot only at the edge; table full this cycle
    v = cand(INT, 6'd1, 6'd11); v.rv = 1; v.r = F+2;
    apply(v);
    chk("R8 full with same-cycle retire", int'(stall), 1);
    apply(cand(INT, 6'd1, 6'd11));
    chk("R6 slot reused after retire", int'(issue), 1);
    chk("R6 pending count before alloc", $countones(pend_valid), 3);

    // R1: reset clears table and divider mid-run
    @(negedge clk); rst_n = 1'b0; cand_valid = 0; ret_valid = 0;
    #1;
    chk("R1 pend_valid after reset", int'(pend_valid), 0);
    chk("R1 div_busy after reset", int'(div_busy), 0);
    @(negedge clk); rst_n = 1'b1;

    // R5: divider initiation interval
    apply(cand(DIV, F+4, F+1));
    chk("R5 first divide issues", int'(issue), 1);
    apply(cand(MUL, F+4, F+5));
    chk("R5 div_busy after divide", int'(div_busy), 1);
    chk("R5 multiply not held by divider", int'(issue), 1);
    k = 2;
    apply(cand(DIV, F+6, F+3));
    while (!issue && k < 60) begin
      k++;
      apply(cand(DIV, F+6, F+3));
    end
    chk("R5 cycles between divides", k, DIV_II);
    apply(cand(ADD, F+1, F+9));
    chk("R2 source pending from divide", int'(stall), 1);

    @(negedge clk); cand_valid = 0;
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule